// File: doc/BRIEF.md
# Peripheral Clock Gate and Divider Unit

This unit turns two free-running timing references into per-peripheral clock-enable pulses, all in one fast clock domain. One reference is an external tick. The other is a PLL tick, which can be thinned to every second tick to form the half-rate PLL source. Software writes a small set of registers over a simple write bus. These registers stop or run each of sixteen peripheral channels, pick a source for the channels that have a choice, and set a divide value for the channels that have a divider.

A channel without a divider passes the external tick through its stop bit. A divided channel has three parts: a source mux, a counter that divides by the field value plus one, and an active-high stop bit. When a divided channel selects the external source, its divider is bypassed. There is also one extra ungated output, the LCD device enable, which always divides the half-rate PLL source.

Register map (word address on `wrAddr`): 0 control, 1 stop mask, 2 audio divide, 3 LCD pixel divide, 4 MMC divide, 5 USB host divide, 6 SPI divide and source.

Top module: `periph_clk_unit`

## Requirements
- R1: Setting bit i of the stop mask (address 1) suppresses every pulse on `chanEn[i]`. Clearing the bit lets pulses through again. The new value applies from the cycle after the write.
- R2: Output index equals stop-mask bit. The divided channels sit at 4 (SPI), 6 (audio), 7 (MMC), 10 (LCD pixel), 11 (USB device) and 14 (USB host). Every other index is an external-tick pass-through.
- R3: A divided channel that takes the half-rate PLL source gives exactly one pulse every (field+1) half-rate ticks.
- R4: A selectable channel (audio, SPI, USB device) whose select bit is clear passes the external tick unchanged, whatever its divide field holds.
- R5: The divide fields sit in the low bits of their registers and are 9 bits wide for audio and LCD pixel, 5 bits for MMC, and 4 bits for USB host and SPI. Higher data bits are ignored.
- R6: The USB device divide field is control bits 28:23. Its source select is control bit 29, where 1 means the half-rate PLL.
- R7: The audio source select is control bit 31. The SPI source select is bit 31 of the SPI register. For both, 1 means the half-rate PLL.
- R8: When control bit 21 is clear, the half-rate PLL source equals the PLL tick. When it is set, the source keeps every second PLL tick.
- R9: `lcdDevEn` pulses once every (control[20:16]+1) half-rate PLL ticks and has no stop bit.
- R10: A newly written divide value takes effect only after the channel's current period completes. The counter never passes its terminal value.
- R11: After reset, every divide field is 0, every select picks the external tick, and every stop bit is clear.
- R12: Channels without a divider pulse exactly on each external tick while their stop bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| extTick | input | 1 | External reference tick, one cycle wide |
| pllTick | input | 1 | PLL tick, one cycle wide |
| chanEn | output | 16 | Per-peripheral clock enables |
| lcdDevEn | output | 1 | LCD device clock enable |

## Verification
The assertions assume each tick input is a single-cycle level sampled on the fast clock. They also assume that a half-rate tick seen with bit 21 set cannot repeat on the very next cycle while the bit stays set. The stimulus holds the PLL tick high on every cycle, raises the external tick on every third cycle, and changes the configuration only through the write bus. Rates are measured only after a warm-up long enough for any period already in progress to finish. Each count window is a whole number of periods of both the channel under test and the external tick, so the expected counts are exact integers.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int NCH  = 16;
  localparam int MAXW = 9;
  localparam int LDW  = 5;
  localparam int AW   = 3;
  localparam int DW   = 32;

  localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADDR_STOP = 3'd1;
  localparam logic [AW-1:0] ADDR_AUD  = 3'd2;
  localparam logic [AW-1:0] ADDR_LPIX = 3'd3;
  localparam logic [AW-1:0] ADDR_MMC  = 3'd4;
  localparam logic [AW-1:0] ADDR_UHC  = 3'd5;
  localparam logic [AW-1:0] ADDR_SPI  = 3'd6;

  localparam int CH_SPI = 4;
  localparam int CH_AUD = 6;
  localparam int CH_MMC = 7;
  localparam int CH_LPX = 10;
  localparam int CH_UDC = 11;
  localparam int CH_UHC = 14;

  // divider width per channel index; 0 means a plain pass-through channel
  function automatic int divWidth(input int ch);
    case (ch)
      CH_SPI:  return 4;
      CH_AUD:  return 9;
      CH_MMC:  return 5;
      CH_LPX:  return 9;
      CH_UDC:  return 6;
      CH_UHC:  return 4;
      default: return 0;
    endcase
  endfunction

  typedef struct packed {
    logic [NCH-1:0]           stop;
    logic [NCH-1:0]           usePll;
    logic [NCH-1:0][MAXW-1:0] divField;
    logic                     halfMode;
    logic [LDW-1:0]           lcdDevDiv;
  } pcu_cfg_t;
endpackage

// File: rtl/pcu_regs.sv
module pcu_regs
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output pcu_cfg_t      cfg
);
  logic           audSrc, udcSrc, spiSrc, halfMode;
  logic [5:0]     udcDiv;
  logic [LDW-1:0] lcdDevDiv;
  logic [NCH-1:0] stopMask;
  logic [8:0]     audDiv, lpixDiv;
  logic [4:0]     mmcDiv;
  logic [3:0]     uhcDiv, spiDiv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      audSrc <= 1'b0; udcSrc <= 1'b0; spiSrc <= 1'b0; halfMode <= 1'b0;
      udcDiv <= '0; lcdDevDiv <= '0; stopMask <= '0;
      audDiv <= '0; lpixDiv <= '0; mmcDiv <= '0; uhcDiv <= '0; spiDiv <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          audSrc    <= wrData[31];
          udcSrc    <= wrData[29];
          udcDiv    <= wrData[28:23];
          halfMode  <= wrData[21];
          lcdDevDiv <= wrData[20:16];
        end
        ADDR_STOP: stopMask <= wrData[NCH-1:0];
        ADDR_AUD:  audDiv   <= wrData[8:0];
        ADDR_LPIX: lpixDiv  <= wrData[8:0];
        ADDR_MMC:  mmcDiv   <= wrData[4:0];
        ADDR_UHC:  uhcDiv   <= wrData[3:0];
        ADDR_SPI: begin
          spiSrc <= wrData[31];
          spiDiv <= wrData[3:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg = '0;
    cfg.stop               = stopMask;
    cfg.halfMode           = halfMode;
    cfg.lcdDevDiv          = lcdDevDiv;
    cfg.usePll[CH_SPI]     = spiSrc;
    cfg.usePll[CH_AUD]     = audSrc;
    cfg.usePll[CH_MMC]     = 1'b1;
    cfg.usePll[CH_LPX]     = 1'b1;
    cfg.usePll[CH_UDC]     = udcSrc;
    cfg.usePll[CH_UHC]     = 1'b1;
    cfg.divField[CH_SPI]   = MAXW'(spiDiv);
    cfg.divField[CH_AUD]   = MAXW'(audDiv);
    cfg.divField[CH_MMC]   = MAXW'(mmcDiv);
    cfg.divField[CH_LPX]   = MAXW'(lpixDiv);
    cfg.divField[CH_UDC]   = MAXW'(udcDiv);
    cfg.divField[CH_UHC]   = MAXW'(uhcDiv);
  end

  // stop mask changes only through a write to its address
  assert_stop_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_STOP) |=> $stable(stopMask));
endmodule

// File: rtl/pcu_div_chan.sv
module pcu_div_chan #(
  parameter int W    = 4,
  parameter int MAXW = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            extTick,
  input  logic            halfTick,
  input  logic            usePll,
  input  logic [MAXW-1:0] divVal,
  input  logic            stop,
  output logic            outEn
);
  logic [W-1:0] cnt, cur;
  logic         advance, term;

  assign advance = usePll && halfTick;
  assign term    = advance && (cnt == cur);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      cur <= '0;
    end else if (advance) begin
      if (cnt == cur) begin
        cnt <= '0;
        cur <= divVal[W-1:0];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign outEn = (usePll ? term : extTick) && !stop;

  generate
    if (W < MAXW) begin : g_hi
      logic unusedHi;
      assign unusedHi = ^divVal[MAXW-1:W];
    end
  endgenerate

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= cur);
  assert_cur_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !term |=> $stable(cur));
  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> !outEn);
endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           extTick,
  input  logic           pllTick,
  input  pcu_cfg_t       cfg,
  output logic [NCH-1:0] chanEn,
  output logic           lcdDevEn
);
  logic halfPhase, halfTick;

  always_ff @(posedge clk) begin
    if (!rstN || !cfg.halfMode) halfPhase <= 1'b0;
    else if (pllTick)           halfPhase <= ~halfPhase;
  end

  assign halfTick = pllTick && (!cfg.halfMode || halfPhase);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      localparam int W = divWidth(i);
      if (W > 0) begin : g_div
        pcu_div_chan #(.W(W), .MAXW(MAXW)) u_chan (
          .clk(clk), .rstN(rstN), .extTick(extTick), .halfTick(halfTick),
          .usePll(cfg.usePll[i]), .divVal(cfg.divField[i]),
          .stop(cfg.stop[i]), .outEn(chanEn[i]));
      end else begin : g_pass
        assign chanEn[i] = extTick && !cfg.stop[i];
      end
    end
  endgenerate

  pcu_div_chan #(.W(LDW), .MAXW(MAXW)) u_lcdDev (
    .clk(clk), .rstN(rstN), .extTick(extTick), .halfTick(halfTick),
    .usePll(1'b1), .divVal({{(MAXW-LDW){1'b0}}, cfg.lcdDevDiv}),
    .stop(1'b0), .outEn(lcdDevEn));

  logic unusedCfg;
  assign unusedCfg = ^cfg;

  assert_half_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.halfMode && halfTick) |=> !(cfg.halfMode && halfTick));
  assert_half_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> pllTick);
endmodule

// File: rtl/periph_clk_unit.sv
module periph_clk_unit
  import pcu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  logic          extTick,
  input  logic          pllTick,
  output logic [15:0]   chanEn,
  output logic          lcdDevEn
);
  pcu_cfg_t cfg;

  pcu_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cfg(cfg));

  pcu_datapath u_dp (
    .clk(clk), .rstN(rstN), .extTick(extTick), .pllTick(pllTick),
    .cfg(cfg), .chanEn(chanEn), .lcdDevEn(lcdDevEn));
endmodule

// File: tb/periph_clk_unit_test.sv
`timescale 1ns/1ps
module periph_clk_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        extTick = 1'b0;
  logic        pllTick = 1'b1;
  logic [15:0] chanEn;
  logic        lcdDevEn;

  int checks = 0;
  int errors = 0;
  int cnt [17];
  int lastD [17];
  int ph = 0;
  logic [31:0] ctrlW = '0;

  periph_clk_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTick(extTick), .pllTick(pllTick), .chanEn(chanEn), .lcdDevEn(lcdDevEn));

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      extTick <= (ph == 0);
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(input int n);
    for (int b = 0; b < 17; b++) cnt[b] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      for (int b = 0; b < 16; b++) if (chanEn[b]) cnt[b]++;
      if (lcdDevEn) cnt[16]++;
    end
  endtask

  // warm up, then count over 3 whole periods of the channel under test
  task automatic runChan(input int ch, input int d, input int p, input string tag);
    repeat (2 * (lastD[ch] + 1) + p + 4) @(negedge clk);
    measure(3 * p);
    check(tag, cnt[ch], 3);
    check({tag, " ext ref"}, cnt[0], p);
    lastD[ch] = d;
  endtask

  initial begin
    for (int b = 0; b < 17; b++) lastD[b] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state: 30-cycle window = 10 external ticks, 30 PLL ticks
    measure(30);
    for (int b = 0; b < 16; b++) begin
      if (b == 7 || b == 10 || b == 14)
        check($sformatf("R11 divide 0 ch%0d", b), cnt[b], 30);
      else if (b == 4 || b == 6 || b == 11)
        check($sformatf("R11 ext select ch%0d", b), cnt[b], 10);
      else
        check($sformatf("R12 R2 pass ch%0d", b), cnt[b], 10);
    end
    check("R11 lcdDev", cnt[16], 30);

    // MMC sweep over every divide value
    for (int d = 0; d < 32; d++) begin
      wr(3'd4, d);
      runChan(7, d, d + 1, (d == 31) ? "R5 MMC max" : $sformatf("R3 MMC d=%0d", d));
    end

    // half-rate PLL
    ctrlW[21] = 1'b1; wr(3'd0, ctrlW);
    wr(3'd4, 3);
    runChan(7, 3, 8, "R8 half MMC d=3");
    ctrlW[20:16] = 5'd31; wr(3'd0, ctrlW);
    runChan(16, 31, 64, "R9 lcdDev d=31 half");
    ctrlW[21] = 1'b0; ctrlW[20:16] = 5'd2; wr(3'd0, ctrlW);
    runChan(16, 2, 3, "R9 lcdDev d=2");

    // audio
    wr(3'd2, 32'h0000_FFFF);
    ctrlW[31] = 1'b1; wr(3'd0, ctrlW);
    runChan(6, 511, 512, "R7 R5 audio pll d=511");
    ctrlW[31] = 1'b0; wr(3'd0, ctrlW);
    wr(3'd2, 100);
    repeat (10) @(negedge clk);
    measure(30);
    check("R4 audio ext bypass", cnt[6], 10);

    // SPI
    wr(3'd6, 32'h8000_00FF);
    runChan(4, 15, 16, "R7 R5 SPI pll d=15");
    wr(3'd6, 32'h0000_0009);
    repeat (10) @(negedge clk);
    measure(30);
    check("R4 SPI ext bypass", cnt[4], 10);

    // USB device
    ctrlW[29] = 1'b1; ctrlW[28:23] = 6'd63; wr(3'd0, ctrlW);
    runChan(11, 63, 64, "R6 USB dev d=63");
    ctrlW[28:23] = 6'd5; wr(3'd0, ctrlW);
    runChan(11, 5, 6, "R6 USB dev d=5");
    ctrlW[29] = 1'b0; wr(3'd0, ctrlW);
    repeat (10) @(negedge clk);
    measure(30);
    check("R4 USB dev ext bypass", cnt[11], 10);

    // LCD pixel and USB host
    wr(3'd3, 300);
    runChan(10, 300, 301, "R5 LCD pixel d=300");
    wr(3'd5, 32'h1F);
    runChan(14, 15, 16, "R5 USB host upper bit ignored");

    // stop mask
    wr(3'd1, 32'h0000_0081);
    measure(30);
    check("R1 stop ch0", cnt[0], 0);
    check("R1 stop ch7", cnt[7], 0);
    check("R1 neighbour ch1 runs", cnt[1], 10);
    wr(3'd1, 32'h0000_0000);
    measure(30);
    check("R1 run ch0", cnt[0], 10);

    // late take-up of a new divide value
    wr(3'd4, 31);
    repeat (2 * (lastD[7] + 1) + 70) @(negedge clk);
    lastD[7] = 31;
    do begin @(negedge clk); #1; end while (!chanEn[7]);
    wr(3'd4, 2);
    measure(20);
    check("R10 old period completes", cnt[7], 0);
    runChan(7, 2, 3, "R10 new value after terminal");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule